// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a memory-mapped timer with a 32-bit register interface. An up-counter advances on a prescaled clock enable drawn from one of three sources: a bus-clock tick, a peripheral-clock tick, or an oscillator tick that goes through its own divider first. Software reads the live count, adds a delta to it and writes the sum to a single compare register. When the counter steps onto that value, a sticky status flag is raised. If its enable bit is set, the flag drives a level interrupt. Software clears the flag by writing a one to it.

In free-run mode the counter is never reset by a match. It wraps modulo 2^32, and the compare is an exact equality. A target that is already behind the count therefore fires only after a full wrap. In restart mode the counter returns to zero on the tick after it reaches the compare value. All clock sources are modelled as single-cycle enable pulses in the one system clock domain.

Register map (byte offsets): control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, count 0x24 (read-only).

Top module: `gp_match_timer`

## Requirements
- R1: While control bit 0 (enable) is 0, the count is held at 0 and both prescalers are cleared. Source ticks have no effect.
- R2: Control bits 8:6 pick the source: 1 = bus tick, 2 = peripheral tick, 5 = oscillator path. Any other value stops counting. Ticks on an unselected source are ignored.
- R3: Prescaler register bits 11:0 hold value M. The count rises by exactly one for every M+1 ticks of the selected source, counted from enable.
- R4: On the oscillator path, with control bit 10 clear, oscillator ticks are divided by a fixed 8. With bit 10 set they are divided by F+1, where F is prescaler bits 15:12. The result then feeds the main prescaler.
- R5: While input low_power_wait is high and control bit 3 is 0, the count and prescalers freeze. With bit 3 set, counting continues.
- R6: Status bit 0 is set on the clock edge at which the counter advances to a value equal to the compare register. Writing a compare value equal to a stationary count does not set it.
- R7: With control bit 9 set (free-run), the count passes through the compare value by one and keeps incrementing. A compare value below the count does not fire.
- R8: With control bit 9 clear (restart), the advance that follows a count equal to the compare value loads 0.
- R9: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clearing write leaves it set.
- R10: irq equals status bit 0 AND interrupt-enable bit 0, updated on the same edge as either.
- R11: Read data appears on bus_rdata one cycle after bus_rd. Control reads back only bits 0, 3, 6-10 (mask 0x7C9). Prescaler reads back bits 15:0. Interrupt enable reads back bit 0. Writes to the count register are ignored.
- R12: Writing 0 to the control and prescaler registers returns the timer to an idle state: the count reads 0 and does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_bus | input | 1 | Bus-clock enable pulse |
| tick_per | input | 1 | Peripheral-clock enable pulse |
| tick_osc | input | 1 | Oscillator enable pulse |
| low_power_wait | input | 1 | System is in the low-power wait state |
| irq | output | 1 | Level compare interrupt |

## Verification
A source tick presented before a rising edge moves the count at that same edge, because the prescalers are combinational on the tick. A match raises the status flag and the interrupt line at that same edge too. A read strobe returns data one edge later, and that data holds the count as it stood before the edge. The bench therefore drives every input just after a falling edge and samples every output at the next falling edge. It keeps ticks low during register reads, so that each expected count is a plain quotient of ticks delivered over the divide ratios.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 32;

  // register byte offsets
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_PRESC = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_IE    = 8'h0C;
  localparam logic [7:0] OFF_CMP   = 8'h10;
  localparam logic [7:0] OFF_CNT   = 8'h24;

  // control bit positions
  localparam int B_EN     = 0;
  localparam int B_WAIT   = 3;
  localparam int B_SRC    = 6;
  localparam int B_FREE   = 9;
  localparam int B_FAST   = 10;
  localparam int ODIV_LSB = 12;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BUS  = 3'd1,
    SRC_PER  = 3'd2,
    SRC_OSC  = 3'd5
  } src_e;

  typedef struct packed {
    logic       fast_en;
    logic       free_run;
    logic [2:0] src;
    logic       wait_run;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] limit,
  output logic         tick_out
);
  logic [W-1:0] cnt_q;
  logic         at_lim;

  assign at_lim   = (cnt_q >= limit);
  assign tick_out = tick_in && at_lim;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (tick_in)
      cnt_q <= at_lim ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/tmr_tick_path.sv
module tmr_tick_path
  import tmr_pkg::*;
#(
  parameter int MDIV_W        = 12,
  parameter int ODIV_W        = 4,
  parameter int OSC_FIXED_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [MDIV_W-1:0] main_div,
  input  logic [ODIV_W-1:0] osc_div,
  input  logic              tick_bus,
  input  logic              tick_per,
  input  logic              tick_osc,
  input  logic              low_power_wait,
  output logic              adv
);
  localparam logic [ODIV_W-1:0] OSC_FIXED_LIM = ODIV_W'(OSC_FIXED_DIV - 1);

  logic              run;
  logic              osc_out;
  logic              sel_tick;
  logic [ODIV_W-1:0] osc_lim;

  assign run     = ctrl.en && (!low_power_wait || ctrl.wait_run);
  assign osc_lim = ctrl.fast_en ? osc_div : OSC_FIXED_LIM;

  tmr_prescale #(.W(ODIV_W)) u_osc_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (!ctrl.en),
    .tick_in (tick_osc && run),
    .limit   (osc_lim),
    .tick_out(osc_out)
  );

  always_comb begin
    case (ctrl.src)
      SRC_BUS: sel_tick = tick_bus && run;
      SRC_PER: sel_tick = tick_per && run;
      SRC_OSC: sel_tick = osc_out;
      default: sel_tick = 1'b0;
    endcase
  end

  tmr_prescale #(.W(MDIV_W)) u_main_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (!ctrl.en),
    .tick_in (sel_tick),
    .limit   (main_div),
    .tick_out(adv)
  );
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             adv,
  input  logic             free_run,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    if (!free_run && (cnt_q == cmp))
      cnt_nx = '0;
    else
      cnt_nx = cnt_q + CNT_W'(1);
  end

  assign match = en && adv && (cnt_nx == cmp);
  assign cnt   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en)
      cnt_q <= '0;
    else if (adv)
      cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int CNT_W  = 32,
  parameter int MDIV_W = 12,
  parameter int ODIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              match,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic [MDIV_W-1:0] main_div,
  output logic [ODIV_W-1:0] osc_div,
  output logic [CNT_W-1:0]  cmp,
  output logic              flag,
  output logic              ie,
  output logic              irq
);
  logic wr_ctrl, wr_presc, wr_stat, wr_ie, wr_cmp;
  logic flag_d, ie_d;
  logic [REG_W-1:0] rd_mux;

  assign wr_ctrl  = bus_wr && (bus_addr == AW'(OFF_CTRL));
  assign wr_presc = bus_wr && (bus_addr == AW'(OFF_PRESC));
  assign wr_stat  = bus_wr && (bus_addr == AW'(OFF_STAT));
  assign wr_ie    = bus_wr && (bus_addr == AW'(OFF_IE));
  assign wr_cmp   = bus_wr && (bus_addr == AW'(OFF_CMP));

  always_comb begin
    if (match)
      flag_d = 1'b1;
    else if (wr_stat && bus_wdata[0])
      flag_d = 1'b0;
    else
      flag_d = flag;
    ie_d = wr_ie ? bus_wdata[0] : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      main_div <= '0;
      osc_div  <= '0;
      cmp      <= '0;
      flag     <= 1'b0;
      ie       <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.en       <= bus_wdata[B_EN];
        ctrl.wait_run <= bus_wdata[B_WAIT];
        ctrl.src      <= bus_wdata[B_SRC +: 3];
        ctrl.free_run <= bus_wdata[B_FREE];
        ctrl.fast_en  <= bus_wdata[B_FAST];
      end
      if (wr_presc) begin
        main_div <= bus_wdata[MDIV_W-1:0];
        osc_div  <= bus_wdata[ODIV_LSB +: ODIV_W];
      end
      if (wr_cmp)
        cmp <= bus_wdata[CNT_W-1:0];
      flag <= flag_d;
      ie   <= ie_d;
      irq  <= flag_d && ie_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFF_CTRL): begin
        rd_mux[B_EN]       = ctrl.en;
        rd_mux[B_WAIT]     = ctrl.wait_run;
        rd_mux[B_SRC +: 3] = ctrl.src;
        rd_mux[B_FREE]     = ctrl.free_run;
        rd_mux[B_FAST]     = ctrl.fast_en;
      end
      AW'(OFF_PRESC): begin
        rd_mux[MDIV_W-1:0]          = main_div;
        rd_mux[ODIV_LSB +: ODIV_W]  = osc_div;
      end
      AW'(OFF_STAT):  rd_mux[0] = flag;
      AW'(OFF_IE):    rd_mux[0] = ie;
      AW'(OFF_CMP):   rd_mux[CNT_W-1:0] = cmp;
      AW'(OFF_CNT):   rd_mux[CNT_W-1:0] = cnt;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gp_match_timer.sv
module gp_match_timer
  import tmr_pkg::*;
#(
  parameter int AW            = 8,
  parameter int CNT_W         = 32,
  parameter int MDIV_W        = 12,
  parameter int ODIV_W        = 4,
  parameter int OSC_FIXED_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             tick_bus,
  input  logic             tick_per,
  input  logic             tick_osc,
  input  logic             low_power_wait,
  output logic             irq
);
  ctrl_t             ctrl_q;
  logic [MDIV_W-1:0] main_div;
  logic [ODIV_W-1:0] osc_div;
  logic [CNT_W-1:0]  cmp_val;
  logic [CNT_W-1:0]  cnt_val;
  logic              adv;
  logic              match;
  logic              stat_flag;
  logic              ie_bit;
  logic              ctrl_en;
  logic              free_run;

  assign ctrl_en  = ctrl_q.en;
  assign free_run = ctrl_q.free_run;

  tmr_regs #(
    .AW(AW), .CNT_W(CNT_W), .MDIV_W(MDIV_W), .ODIV_W(ODIV_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .match    (match),
    .cnt      (cnt_val),
    .ctrl     (ctrl_q),
    .main_div (main_div),
    .osc_div  (osc_div),
    .cmp      (cmp_val),
    .flag     (stat_flag),
    .ie       (ie_bit),
    .irq      (irq)
  );

  tmr_tick_path #(
    .MDIV_W(MDIV_W), .ODIV_W(ODIV_W), .OSC_FIXED_DIV(OSC_FIXED_DIV)
  ) u_ticks (
    .clk           (clk),
    .rst           (rst),
    .ctrl          (ctrl_q),
    .main_div      (main_div),
    .osc_div       (osc_div),
    .tick_bus      (tick_bus),
    .tick_per      (tick_per),
    .tick_osc      (tick_osc),
    .low_power_wait(low_power_wait),
    .adv           (adv)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_en),
    .adv     (adv),
    .free_run(free_run),
    .cmp     (cmp_val),
    .cnt     (cnt_val),
    .match   (match)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int AW    = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             adv,
  input logic             free_run,
  input logic [CNT_W-1:0] cnt,
  input logic             match,
  input logic             flag,
  input logic             ie,
  input logic             irq,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic             wdata0
);
  logic stat_clr;
  assign stat_clr = bus_wr && (bus_addr == AW'(8'h08)) && wdata0;

  AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));                                           // R1
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (en && !adv) |=> (cnt == $past(cnt)));                          // R3
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && adv && free_run) |=> (cnt == $past(cnt) + CNT_W'(1)));   // R7
  AST_MATCH_RAISES: assert property (@(posedge clk) disable iff (rst)
    match |=> flag);                                                // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_clr) |=> flag);                                  // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie));                                           // R10
endmodule

bind gp_match_timer tmr_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (ctrl_en),
  .adv     (adv),
  .free_run(free_run),
  .cnt     (cnt_val),
  .match   (match),
  .flag    (stat_flag),
  .ie      (ie_bit),
  .irq     (irq),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .wdata0  (bus_wdata[0])
);

// File: tb/tb_gp_match_timer.sv
module tb_gp_match_timer;
  localparam int AW = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_PRESC = 8'h04, A_STAT = 8'h08,
                         A_IE = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          tick_bus = 1'b0, tick_per = 1'b0, tick_osc = 1'b0;
  logic          low_power_wait = 1'b0;
  logic          irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gp_match_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
    .tick_per(tick_per), .tick_osc(tick_osc), .low_power_wait(low_power_wait),
    .irq(irq)
  );

  function automatic logic [31:0] mk_ctrl(bit en, bit wrun, int src, bit free, bit fast);
    return 32'(en) | (32'(wrun) << 3) | (32'(src & 7) << 6) | (32'(free) << 9) | (32'(fast) << 10);
  endfunction

  function automatic int exp_div(int ticks, int d);
    return ticks / (d + 1);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // kind: 0 bus, 1 per, 2 osc; delivers n pulses with random gaps
  task automatic pulses(int kind, int n);
    int sent = 0;
    while (sent < n) begin
      @(negedge clk);
      tick_bus = 1'b0; tick_per = 1'b0; tick_osc = 1'b0;
      if ($urandom_range(2) != 0) begin
        if (kind == 0) tick_bus = 1'b1;
        else if (kind == 1) tick_per = 1'b1;
        else tick_osc = 1'b1;
        sent++;
      end
    end
    @(negedge clk);
    tick_bus = 1'b0; tick_per = 1'b0; tick_osc = 1'b0;
  endtask

  task automatic restart(logic [31:0] presc, logic [31:0] ctrl);
    wr(A_CTRL, 32'h0);
    wr(A_PRESC, presc);
    wr(A_CTRL, ctrl);
  endtask

  initial begin
    logic [31:0] v, c;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(A_CTRL, v); chk("R11 reset ctrl", v, 32'h0);
    rd(A_CNT, v);  chk("R1 reset count", v, 32'h0);
    rd(A_STAT, v); chk("R6 reset status", v, 32'h0);
    n_run++; if (irq !== 1'b0) begin n_fail++; $display("FAIL R10 reset irq got %b expected 0", irq); end

    // R1: disabled ignores ticks
    wr(A_CTRL, mk_ctrl(0, 0, 1, 1, 0));
    pulses(0, 10);
    rd(A_CNT, v); chk("R1 disabled count", v, 32'h0);

    // R3: random main divider on bus and peripheral sources
    for (int i = 0; i < 4; i++) begin
      int d = $urandom_range(4);
      int n = 10 + $urandom_range(30);
      int k = i % 2;
      restart(32'(d), mk_ctrl(1, 0, k ? 2 : 1, 1, 0));
      pulses(k, n);
      rd(A_CNT, v); chk("R3 divided count", v, 32'(exp_div(n, d)));
    end

    // R2: unselected and invalid sources
    restart(32'h0, mk_ctrl(1, 0, 1, 1, 0));
    pulses(1, 12);
    rd(A_CNT, v); chk("R2 unselected source", v, 32'h0);
    restart(32'h0, mk_ctrl(1, 0, 3, 1, 0));
    pulses(0, 12);
    rd(A_CNT, v); chk("R2 invalid source code", v, 32'h0);

    // R4: oscillator path fixed and programmable divide
    restart(32'h0, mk_ctrl(1, 0, 5, 1, 0));
    pulses(2, 24);
    rd(A_CNT, v); chk("R4 fixed osc divide", v, 32'd3);
    restart((32'd2 << 12) | 32'd1, mk_ctrl(1, 0, 5, 1, 1));
    pulses(2, 30);
    rd(A_CNT, v); chk("R4 fast osc divide", v, 32'(exp_div(exp_div(30, 2), 1)));

    // R5: wait state
    restart(32'h0, mk_ctrl(1, 0, 1, 1, 0));
    low_power_wait = 1'b1;
    pulses(0, 10);
    rd(A_CNT, v); chk("R5 frozen in wait", v, 32'h0);
    restart(32'h0, mk_ctrl(1, 1, 1, 1, 0));
    pulses(0, 10);
    rd(A_CNT, v); chk("R5 runs in wait", v, 32'd10);
    low_power_wait = 1'b0;

    // R6 / R10: scheduled match
    wr(A_IE, 32'h1);
    rd(A_CNT, c);
    wr(A_CMP, c + 32'd5);
    pulses(0, 4);
    rd(A_STAT, v); chk("R6 no flag before match", v, 32'h0);
    n_run++; if (irq !== 1'b0) begin n_fail++; $display("FAIL R10 early irq got %b expected 0", irq); end
    pulses(0, 1);
    rd(A_STAT, v); chk("R6 flag on match", v, 32'h1);
    n_run++; if (irq !== 1'b1) begin n_fail++; $display("FAIL R10 irq got %b expected 1", irq); end

    // R10: masking
    wr(A_IE, 32'h0);
    n_run++; if (irq !== 1'b0) begin n_fail++; $display("FAIL R10 masked irq got %b expected 0", irq); end
    wr(A_IE, 32'h1);
    n_run++; if (irq !== 1'b1) begin n_fail++; $display("FAIL R10 unmasked irq got %b expected 1", irq); end

    // R9: write 0 no effect, write 1 clears
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R9 write zero keeps flag", v, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R9 write one clears", v, 32'h0);
    n_run++; if (irq !== 1'b0) begin n_fail++; $display("FAIL R10 cleared irq got %b expected 0", irq); end

    // R7: free-run passes through compare and behind target does not fire
    rd(A_CNT, c);
    chk("R7 count past compare", c, 32'd15);
    wr(A_CMP, c - 32'd1);
    pulses(0, 50);
    rd(A_STAT, v); chk("R7 behind target silent", v, 32'h0);
    rd(A_CNT, v);  chk("R7 count keeps rising", v, c + 32'd50);

    // R6: compare written equal to a stationary count
    rd(A_CNT, c);
    wr(A_CMP, c);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R6 static equal no flag", v, 32'h0);

    // R9: match and clear in the same cycle
    wr(A_CMP, c + 32'd1);
    @(negedge clk);
    tick_bus = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    tick_bus = 1'b0; bus_wr = 1'b0;
    rd(A_STAT, v); chk("R9 match beats clear", v, 32'h1);
    wr(A_STAT, 32'h1);

    // R8: restart mode
    restart(32'h0, mk_ctrl(1, 0, 1, 0, 0));
    wr(A_CMP, 32'd3);
    pulses(0, 5);
    rd(A_CNT, v);  chk("R8 restart count", v, 32'd1);
    rd(A_STAT, v); chk("R8 restart flag", v, 32'h1);
    wr(A_STAT, 32'h1);

    // R11: readback masks and read-only count
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R11 ctrl mask", v, 32'h0000_07C9);
    wr(A_PRESC, 32'hFFFF_FFFF);
    rd(A_PRESC, v); chk("R11 presc mask", v, 32'h0000_FFFF);
    wr(A_IE, 32'hFFFF_FFFE);
    rd(A_IE, v); chk("R11 ie mask", v, 32'h0);
    restart(32'h0, mk_ctrl(1, 0, 1, 1, 0));
    pulses(0, 6);
    wr(A_CNT, 32'hDEAD_BEEF);
    rd(A_CNT, v); chk("R11 count read-only", v, 32'd6);

    // R12: idle state
    wr(A_CTRL, 32'h0);
    wr(A_PRESC, 32'h0);
    pulses(0, 8);
    rd(A_CNT, v);   chk("R12 idle count", v, 32'h0);
    rd(A_PRESC, v); chk("R12 idle presc", v, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule